// File: doc/BRIEF.md
# Interrupt Redirection Table with End-of-Interrupt Clear

This block keeps a table of interrupt redirection entries and watches one interrupt line per entry. Each entry holds a vector, a trigger-mode bit, a mask bit and a remote-pending flag. An unmasked level-mode entry whose line is high and whose remote-pending flag is clear asks to send a message. When that message is accepted on the valid/ready output, the flag is set, and the entry stays quiet until software signals completion. Edge-mode entries latch each rising edge and send one message per edge.

Software reaches the table through a 32-bit register bus. It writes an index register to select a table dword and then accesses that dword through a data window. A write-only end-of-interrupt register takes a vector in its low byte. In one cycle it clears the remote-pending flag of every entry that holds that vector. A level input that is still high after its flag clears sends a new message at once. When several entries compete, the lowest-numbered entry wins.

Top module: `irq_route_table`

## Requirements
- R1: After reset the index register reads 0, the data window reads 0, every entry's low dword reads 0x0001_0000 (masked, edge mode, vector 0, not pending) and `msg_valid` is low.
- R2: The index register sits at bus offset 0x00 and its bits 7:0 are read back. The data window sits at offset 0x10. Entry n's low dword is at index 0x10+2n and its high dword at 0x11+2n. The high dword and every index outside the table read 0 and ignore writes. Read data appears on `bus_rdata` one clock after the read request.
- R3: Low dword fields: bits 7:0 vector, bit 14 remote-pending (read-only), bit 15 trigger mode (1 = level, 0 = edge), bit 16 mask (1 = masked). All other bits read 0.
- R4: Only dword accesses count. An access whose address bits 1:0 are non-zero changes nothing and reads 0, and unmapped offsets read 0.
- R5: An unmasked level entry with its line high and remote-pending clear drives `msg_valid` with its vector in the same cycle. The accepting handshake sets its remote-pending bit, and no further message follows while the bit stays set.
- R6: A write to offset 0x40 compares write-data bits 7:0 with every entry's vector and clears remote-pending on all entries that match, including several sharing a vector. Bits 31:8 are ignored, and the register reads 0.
- R7: If a level entry's line is still high when its remote-pending bit is cleared, the entry requests again in the next cycle.
- R8: Among entries requesting at once, the lowest-numbered one is presented, and one message leaves per accepted handshake.
- R9: An unmasked edge entry sends exactly one message per rising edge of its line, even if the line stays high, and never sets remote-pending.
- R10: A masked entry never drives `msg_valid`. A level line held high while masked is sent once the mask is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Register access request, one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_in | input | NUM_ENT | Interrupt lines, synchronous to `clk` |
| msg_valid | output | 1 | An interrupt message is offered |
| msg_ready | input | 1 | The consumer accepts the offered message |
| msg_vector | output | 8 | Vector of the offered message |

## Verification
The checks assume that the interrupt lines are already synchronous to `clk`, and that `bus_valid` lasts one cycle per access with stable address and data. They also assume the consumer raises `msg_ready` only while it samples `msg_valid`. The stimulus changes every input at the falling edge, gives each register access a single rising edge, and changes interrupt lines only between bus accesses. In this way every edge detection and remote-pending update falls in a known cycle. The sweeps cover all entries, vectors shared by several entries, and end-of-interrupt writes with non-zero upper bits.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam logic [7:0] OFS_INDEX = 8'h00;
  localparam logic [7:0] OFS_DATA  = 8'h10;
  localparam logic [7:0] OFS_EOI   = 8'h40;
  localparam logic [7:0] TBL_BASE  = 8'h10;

  localparam int BIT_REMOTE = 14;
  localparam int BIT_LEVEL  = 15;
  localparam int BIT_MASK   = 16;

  typedef struct packed {
    logic [7:0] vec;
    logic       level;
    logic       mask;
  } ent_cfg_t;
endpackage

// File: rtl/irq_regbus.sv
module irq_regbus
  import irq_route_pkg::*;
#(
  parameter int NUM_ENT = 24,
  localparam int SEL_W = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  input  logic [31:0]      tbl_rword,
  output logic [31:0]      bus_rdata,
  output logic             tbl_wr,
  output ent_cfg_t         tbl_wcfg,
  output logic [SEL_W-1:0] tbl_sel,
  output logic             tbl_lo_hit,
  output logic             eoi_wr,
  output logic [7:0]       eoi_vec
);
  localparam logic [7:0] TBL_SPAN = 8'(2 * NUM_ENT);

  logic [7:0]  index_q, index_d;
  logic        index_en;
  logic [31:0] rdata_q, rdata_d;
  logic        rdata_en;
  logic        aligned;
  logic [7:0]  rel;
  logic        in_tbl;
  logic        unused_bits;

  assign aligned = bus_valid && (bus_addr[1:0] == 2'b00);

  // index decode
  assign rel        = index_q - TBL_BASE;
  assign in_tbl     = (index_q >= TBL_BASE) && (rel < TBL_SPAN);
  assign tbl_sel    = rel[SEL_W:1];
  assign tbl_lo_hit = in_tbl && !rel[0];

  assign tbl_wr   = aligned && bus_write && (bus_addr == OFS_DATA) && tbl_lo_hit;
  assign tbl_wcfg = '{vec: bus_wdata[7:0], level: bus_wdata[BIT_LEVEL], mask: bus_wdata[BIT_MASK]};
  assign eoi_wr   = aligned && bus_write && (bus_addr == OFS_EOI);
  assign eoi_vec  = bus_wdata[7:0];

  assign unused_bits = ^{bus_wdata[31:17], bus_wdata[14:8], rel[7:SEL_W+1]};

  always_comb begin
    index_en = aligned && bus_write && (bus_addr == OFS_INDEX);
    index_d  = bus_wdata[7:0];
  end

  always_comb begin
    rdata_en = bus_valid && !bus_write;
    rdata_d  = '0;
    if (aligned) begin
      if (bus_addr == OFS_INDEX)
        rdata_d = {24'd0, index_q};
      else if (bus_addr == OFS_DATA)
        rdata_d = tbl_rword;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= '0;
      rdata_q <= '0;
    end else begin
      if (index_en) index_q <= index_d;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;

  AST_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write && bus_addr == OFS_INDEX) |=> $stable(index_q)); // R4
endmodule

// File: rtl/irq_entry.sv
module irq_entry
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  ent_cfg_t    wr_cfg,
  input  logic        eoi_wr,
  input  logic [7:0]  eoi_vec,
  input  logic        irq_line,
  input  logic        grant,
  output logic [31:0] lo_word,
  output logic        req
);
  ent_cfg_t cfg_q;
  logic     remote_q, remote_d;
  logic     edge_q, edge_d;
  logic     irq_d;
  logic     rise;
  logic     eoi_hit;

  assign rise    = irq_line && !irq_d && !cfg_q.mask && !cfg_q.level;
  assign eoi_hit = eoi_wr && (eoi_vec == cfg_q.vec);

  always_comb begin
    remote_d = remote_q;
    if (grant && cfg_q.level) remote_d = 1'b1;
    else if (eoi_hit)         remote_d = 1'b0;
  end

  always_comb begin
    if (cfg_q.level) edge_d = 1'b0;
    else             edge_d = (edge_q && !grant) || rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '{vec: 8'd0, level: 1'b0, mask: 1'b1};
      remote_q <= 1'b0;
      edge_q   <= 1'b0;
      irq_d    <= 1'b0;
    end else begin
      if (wr_en) cfg_q <= wr_cfg;
      remote_q <= remote_d;
      edge_q   <= edge_d;
      irq_d    <= irq_line;
    end
  end

  always_comb begin
    if (cfg_q.mask)       req = 1'b0;
    else if (cfg_q.level) req = irq_line && !remote_q;
    else                  req = edge_q;
  end

  always_comb begin
    lo_word             = '0;
    lo_word[7:0]        = cfg_q.vec;
    lo_word[BIT_REMOTE] = remote_q;
    lo_word[BIT_LEVEL]  = cfg_q.level;
    lo_word[BIT_MASK]   = cfg_q.mask;
  end

  AST_REMOTE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    grant && cfg_q.level |=> remote_q); // R5
  AST_REMOTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    remote_q && !eoi_wr |=> remote_q); // R5
  AST_EOI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr && eoi_vec == cfg_q.vec && !grant |=> !remote_q); // R6
  AST_EDGE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    grant && !cfg_q.level && !(irq_line && !irq_d) |=> !edge_q); // R9
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int NUM_ENT = 24,
  localparam int SEL_W = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_ENT-1:0] req,
  output logic               any,
  output logic [SEL_W-1:0]   idx,
  output logic [NUM_ENT-1:0] onehot
);
  always_comb begin
    idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (req[i]) idx = SEL_W'(i);
    end
  end

  assign any = |req;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_oh
    assign onehot[g] = any && (idx == SEL_W'(g));
  end

  AST_PICK_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[idx] && ((req & ((NUM_ENT'(1) << idx) - NUM_ENT'(1))) == '0)); // R8
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_route_pkg::*;
#(
  parameter int NUM_ENT = 24,
  localparam int SEL_W = $clog2(NUM_ENT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_ENT-1:0] irq_in,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [7:0]         msg_vector
);
  logic [1:0]         rst_sync;
  logic               rst_int_n;
  logic               tbl_wr;
  ent_cfg_t           tbl_wcfg;
  logic [SEL_W-1:0]   tbl_sel;
  logic               tbl_lo_hit;
  logic               eoi_wr;
  logic [7:0]         eoi_vec;
  logic [31:0]        tbl_rword;
  logic [31:0]        lo_words [NUM_ENT];
  logic [NUM_ENT-1:0] reqs;
  logic [NUM_ENT-1:0] pick_oh;
  logic [SEL_W-1:0]   pick_idx;
  logic               pick_any;
  logic               accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  irq_regbus #(.NUM_ENT(NUM_ENT)) u_bus (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .tbl_rword  (tbl_rword),
    .bus_rdata  (bus_rdata),
    .tbl_wr     (tbl_wr),
    .tbl_wcfg   (tbl_wcfg),
    .tbl_sel    (tbl_sel),
    .tbl_lo_hit (tbl_lo_hit),
    .eoi_wr     (eoi_wr),
    .eoi_vec    (eoi_vec)
  );

  assign accept = msg_valid && msg_ready;

  for (genvar n = 0; n < NUM_ENT; n++) begin : g_ent
    irq_entry u_ent (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .wr_en    (tbl_wr && (tbl_sel == SEL_W'(n))),
      .wr_cfg   (tbl_wcfg),
      .eoi_wr   (eoi_wr),
      .eoi_vec  (eoi_vec),
      .irq_line (irq_in[n]),
      .grant    (accept && pick_oh[n]),
      .lo_word  (lo_words[n]),
      .req      (reqs[n])
    );
  end

  irq_pick #(.NUM_ENT(NUM_ENT)) u_pick (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .req    (reqs),
    .any    (pick_any),
    .idx    (pick_idx),
    .onehot (pick_oh)
  );

  assign tbl_rword  = tbl_lo_hit ? lo_words[tbl_sel] : 32'd0;
  assign msg_valid  = pick_any;
  assign msg_vector = lo_words[pick_idx][7:0];

  AST_MSG_UNMASKED: assert property (@(posedge clk) disable iff (!rst_int_n)
    msg_valid |-> !lo_words[pick_idx][BIT_MASK]); // R10
  AST_MSG_VECTOR: assert property (@(posedge clk) disable iff (!rst_int_n)
    accept |=> lo_words[$past(pick_idx)][BIT_REMOTE] || !lo_words[$past(pick_idx)][BIT_LEVEL]); // R5
endmodule

// File: tb/tb_irq_route_table.sv
module tb_irq_route_table;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [N-1:0] irq;
  logic        msg_valid, msg_ready;
  logic [7:0]  msg_vector;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_table #(.NUM_ENT(N)) dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq), .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector)
  );

  function automatic logic [31:0] lodw(input logic [7:0] vec, input bit lvl, input bit msk, input bit rem);
    return (32'(msk) << 16) | (32'(lvl) << 15) | (32'(rem) << 14) | 32'(vec);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_ent(input int n, output logic [31:0] d);
    bwr(8'h00, 32'(8'h10 + 2*n));
    brd(8'h10, d);
  endtask

  task automatic wr_ent(input int n, input logic [31:0] d);
    bwr(8'h00, 32'(8'h10 + 2*n));
    bwr(8'h10, d);
  endtask

  task automatic accept1;
    @(negedge clk); msg_ready = 1'b1;
    @(negedge clk); msg_ready = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0;
    bus_wdata = '0; irq = '0; msg_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    brd(8'h00, rd); chk("R1 index", rd, 32'd0);
    brd(8'h10, rd); chk("R1 window", rd, 32'd0);
    chk("R1 no msg", 32'(msg_valid), 32'd0);
    for (int n = 0; n < N; n++) begin
      rd_ent(n, rd); chk("R1 entry", rd, lodw(8'h0, 0, 1, 0));
    end

    // R2 R3 layout sweep: remote bit and stray bits dropped, high dword zero
    for (int n = 0; n < N; n++) begin
      wr_ent(n, 32'h8000_4000 | lodw(8'(8'h20 + n), 1, 1, 0));
      brd(8'h10, rd); chk("R3 low dword", rd, lodw(8'(8'h20 + n), 1, 1, 0));
      bwr(8'h00, 32'(8'h11 + 2*n));
      bwr(8'h10, 32'hFFFF_FFFF);
      brd(8'h10, rd); chk("R2 high dword", rd, 32'd0);
      brd(8'h00, rd); chk("R2 index readback", rd, 32'(8'h11 + 2*n));
    end
    bwr(8'h00, 32'h40); brd(8'h10, rd); chk("R2 outside table", rd, 32'd0);
    bwr(8'h00, 32'h0F); brd(8'h10, rd); chk("R2 below table", rd, 32'd0);

    // R4 misaligned and unmapped
    bwr(8'h00, 32'h16);
    bwr(8'h01, 32'h55);
    brd(8'h00, rd); chk("R4 misaligned write", rd, 32'h16);
    brd(8'h12, rd); chk("R4 misaligned read", rd, 32'd0);
    brd(8'h20, rd); chk("R4 unmapped read", rd, 32'd0);
    brd(8'h40, rd); chk("R6 eoi reads zero", rd, 32'd0);

    // R5 level fire and remote set
    wr_ent(3, lodw(8'h23, 1, 0, 0));
    irq[3] = 1'b1;
    @(negedge clk);
    chk("R5 valid", 32'(msg_valid), 32'd1);
    chk("R5 vector", 32'(msg_vector), 32'h23);
    accept1();
    chk("R5 silent after accept", 32'(msg_valid), 32'd0);
    rd_ent(3, rd); chk("R5 remote set", rd, lodw(8'h23, 1, 0, 1));
    irq[3] = 1'b0;

    // R6 non-matching then matching EOI, upper bits ignored
    bwr(8'h40, 32'hFFFF_FF24);
    rd_ent(3, rd); chk("R6 no match keeps", rd, lodw(8'h23, 1, 0, 1));
    bwr(8'h40, 32'hABCD_EF23);
    rd_ent(3, rd); chk("R6 match clears", rd, lodw(8'h23, 1, 0, 0));

    // R6 R8 shared vector
    wr_ent(5, lodw(8'h40, 1, 0, 0));
    wr_ent(6, lodw(8'h40, 1, 0, 0));
    irq[5] = 1'b1; irq[6] = 1'b1;
    @(negedge clk);
    chk("R8 shared vec first", 32'(msg_vector), 32'h40);
    accept1();
    chk("R8 second offered", 32'(msg_valid), 32'd1);
    accept1();
    chk("R5 both silent", 32'(msg_valid), 32'd0);
    irq[5] = 1'b0; irq[6] = 1'b0;
    rd_ent(5, rd); chk("R5 entry5 remote", rd, lodw(8'h40, 1, 0, 1));
    rd_ent(6, rd); chk("R5 entry6 remote", rd, lodw(8'h40, 1, 0, 1));
    bwr(8'h40, 32'h0000_0040);
    rd_ent(5, rd); chk("R6 shared clear 5", rd, lodw(8'h40, 1, 0, 0));
    rd_ent(6, rd); chk("R6 shared clear 6", rd, lodw(8'h40, 1, 0, 0));

    // R7 refire when line still high
    irq[3] = 1'b1;
    @(negedge clk);
    accept1();
    chk("R7 quiet while pending", 32'(msg_valid), 32'd0);
    bwr(8'h40, 32'h23);
    chk("R7 refire valid", 32'(msg_valid), 32'd1);
    chk("R7 refire vector", 32'(msg_vector), 32'h23);
    accept1();
    irq[3] = 1'b0;
    bwr(8'h40, 32'h23);
    chk("R7 line low no refire", 32'(msg_valid), 32'd0);

    // R8 priority sweep over entries 10..15, one message per handshake
    for (int n = 10; n < 16; n++) wr_ent(n, lodw(8'(8'h20 + n), 1, 0, 0));
    irq[15:10] = 6'h3F;
    @(negedge clk);
    msg_ready = 1'b1;
    for (int n = 10; n < 16; n++) begin
      chk("R8 order valid", 32'(msg_valid), 32'd1);
      chk("R8 order vector", 32'(msg_vector), 32'(8'h20 + n));
      @(negedge clk);
    end
    msg_ready = 1'b0;
    chk("R8 drained", 32'(msg_valid), 32'd0);
    irq[15:10] = '0;
    for (int n = 10; n < 16; n++) bwr(8'h40, 32'(8'h20 + n));

    // R9 edge mode
    wr_ent(20, lodw(8'h34, 0, 0, 0));
    irq[20] = 1'b1;
    @(negedge clk);
    chk("R9 edge valid", 32'(msg_valid), 32'd1);
    chk("R9 edge vector", 32'(msg_vector), 32'h34);
    accept1();
    @(negedge clk);
    chk("R9 once while high", 32'(msg_valid), 32'd0);
    rd_ent(20, rd); chk("R9 no remote", rd, lodw(8'h34, 0, 0, 0));
    irq[20] = 1'b0;
    @(negedge clk);
    irq[20] = 1'b1;
    @(negedge clk);
    chk("R9 second edge", 32'(msg_valid), 32'd1);
    accept1();
    irq[20] = 1'b0;

    // R10 masked level line fires when unmasked
    irq[21] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 masked silent", 32'(msg_valid), 32'd0);
    wr_ent(21, lodw(8'h35, 1, 0, 0));
    chk("R10 unmask fires", 32'(msg_valid), 32'd1);
    chk("R10 vector", 32'(msg_vector), 32'h35);
    accept1();
    irq[21] = 1'b0;
    chk("R10 done", 32'(msg_valid), 32'd0);

    finish_run();
  end
endmodule